// File: doc/BRIEF.md
# Floppy Controller Command and Result Handshake Engine

This block is the host-side engine for a 765-style floppy disk controller. It talks to the controller over a small synchronous register bus. One address selects the main status register and the other selects the data register. Every byte it moves is paced by two status bits. The request-for-master bit (bit 7) says the data register is ready. The direction bit (bit 6) says which way the next byte travels: 1 means from the controller to the host.

A request of kind command sends an opcode and then a chosen number of bytes from a nine-entry parameter table. The engine then collects the result bytes into a seven-entry result table. A request of kind specify builds the timing-setup command from elaboration parameters. A request of kind interrupt waits for the controller's interrupt line and then reads the completion results. If the controller is idle at that point, the engine first asks for interrupt status. An interrupt that reports a drive-ready change while a drive is still seeking is reported as invalid, and the engine goes on waiting. The data-phase transfer and the drive itself are outside this block.

Top module: `fdc_handshake`

## Requirements
- R1: After reset, `done`, `badInt`, `earlyEnd`, `busRd` and `busWr` are 0 and `resCount` is 0.
- R2: No data-register write of a command byte occurs while status bit 4 (controller busy) reads 1.
- R3: Every data-register write is preceded in the previous cycle by a status read showing bit 7 = 1 and bit 6 = 0. Data-register reads require bit 7 = 1 and bit 6 = 1 in the same way.
- R4: A command request writes the opcode first. It then writes parameter slots 0 to `reqLen`-1 in order, where slot k is `reqParams[8k+7:8k]`. `reqLen` is capped at 9.
- R5: If a status read during the command phase shows bit 7 = 1 and bit 6 = 1, the command phase stops early. The remaining bytes are not written, and `done` and `earlyEnd` pulse together.
- R6: Result bytes are stored in arrival order. Slot i appears on `resTable[8i+7:8i]` and `resCount` gives the number stored. Bytes past the seventh are read from the controller but discarded.
- R7: The result phase ends when a status read shows bit 7 = 1 and bit 6 = 0. `done` then pulses with `earlyEnd` at 0, even if no result byte arrived.
- R8: An interrupt request waits for `intLine`. If status bit 4 is then 1, the results are read directly and nothing is written.
- R9: If status bit 4 is 0 at interrupt service, the single byte 0x08 is written before the results are read.
- R10: After interrupt service, the engine checks result slot 0. If its bits 7:6 are 11 and status bits 3:0 are nonzero, `badInt` pulses instead of `done` and the engine waits for `intLine` again. If bits 3:0 are zero, `done` pulses.
- R11: A specify request writes 0x03, then ((16 - step ms) << 4) | (unload ms / 16), then ((load ms / 2) << 1) | non-DMA flag. With the defaults this gives 0x03, 0xAF, 0x33.
- R12: `done` and `badInt` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle request strobe, taken when idle |
| reqKind | input | 2 | 0 command, 1 specify, 2 interrupt service |
| reqOp | input | 8 | Opcode for a command request |
| reqLen | input | 4 | Parameter bytes to send after the opcode |
| reqParams | input | 72 | Parameter table, slot k at bits 8k+7:8k |
| intLine | input | 1 | Controller interrupt line |
| busAddr | output | 1 | 0 status register, 1 data register |
| busRd | output | 1 | One-cycle read strobe |
| busWr | output | 1 | One-cycle write strobe |
| busWdata | output | 8 | Write data |
| busRdata | input | 8 | Read data, valid in the cycle of `busRd` |
| done | output | 1 | Request finished |
| earlyEnd | output | 1 | Qualifies `done`: command phase cut short |
| badInt | output | 1 | Invalid interrupt, still waiting |
| resCount | output | 3 | Result bytes stored |
| resTable | output | 56 | Result table, slot i at bits 8i+7:8i |

## Verification
The bench runs the engine against a controller model whose status bits are paced by its own hold counter. A full read-type command with a busy delay up front confirms ordering and the wait for the busy bit. A seek-like command with no results isolates the empty result phase. A command that the model cuts off after three bytes tells an early end apart from a normal completion. Interrupt service is tried with the busy bit set and with it clear, which separates the direct read from the sense path. A ready-change result with and without seeking bits distinguishes an invalid interrupt from a valid one. An eight-byte result checks that the stored count saturates at seven.

// File: rtl/fdc_hs_pkg.sv
package fdc_hs_pkg;
  localparam int NPARAM = 9;
  localparam int NRES   = 7;
  localparam int RES_W  = $clog2(NRES + 1);

  localparam logic [1:0] K_CMD  = 2'd0;
  localparam logic [1:0] K_SPEC = 2'd1;
  localparam logic [1:0] K_INT  = 2'd2;

  localparam logic [7:0] OP_SPEC  = 8'h03;
  localparam logic [7:0] OP_SENSE = 8'h08;

  typedef struct packed {
    logic loadCmd;
    logic loadSense;
    logic incIdx;
    logic clrRes;
    logic storeRes;
  } hsStrobe_t;
endpackage

// File: rtl/fdc_hs_dp.sv
module fdc_hs_dp
  import fdc_hs_pkg::*;
#(
  parameter int STEP_MS   = 6,
  parameter int UNLOAD_MS = 240,
  parameter int LOAD_MS   = 50,
  parameter int NON_DMA   = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  hsStrobe_t           stb,
  input  logic [1:0]          reqKind,
  input  logic [7:0]          reqOp,
  input  logic [3:0]          reqLen,
  input  logic [8*NPARAM-1:0] reqParams,
  input  logic [7:0]          busRdata,
  output logic [7:0]          busWdata,
  output logic                lastByte,
  output logic [7:0]          res0,
  output logic [RES_W-1:0]    resCount,
  output logic [8*NRES-1:0]   resTable
);
  localparam logic [7:0] SPEC_A = 8'(((16 - STEP_MS) << 4) | (UNLOAD_MS / 16));
  localparam logic [7:0] SPEC_B = 8'(((LOAD_MS / 2) << 1) | NON_DMA);
  localparam logic [3:0] MAX_LEN = 4'(NPARAM);

  logic [7:0]       curOp;
  logic [3:0]       curLen;
  logic             isSpec;
  logic [3:0]       idx;
  logic [3:0]       idxM1;
  logic [7:0]       parTbl [NPARAM];
  logic [7:0]       resTbl [NRES];
  logic [RES_W-1:0] resCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOp  <= '0;
      curLen <= '0;
      isSpec <= 1'b0;
      idx    <= '0;
    end else if (stb.loadCmd) begin
      idx    <= '0;
      isSpec <= (reqKind == K_SPEC);
      curOp  <= (reqKind == K_SPEC) ? OP_SPEC : reqOp;
      curLen <= (reqKind == K_SPEC) ? 4'd2 : ((reqLen > MAX_LEN) ? MAX_LEN : reqLen);
    end else if (stb.loadSense) begin
      idx    <= '0;
      isSpec <= 1'b0;
      curOp  <= OP_SENSE;
      curLen <= '0;
    end else if (stb.incIdx) begin
      idx <= idx + 4'd1;
    end
  end

  for (genvar k = 0; k < NPARAM; k++) begin : g_par
    always_ff @(posedge clk) begin
      if (!rstN)             parTbl[k] <= '0;
      else if (stb.loadCmd)  parTbl[k] <= reqParams[8*k +: 8];
    end
  end

  for (genvar i = 0; i < NRES; i++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rstN || stb.clrRes)
        resTbl[i] <= '0;
      else if (stb.storeRes && resCnt == RES_W'(i))
        resTbl[i] <= busRdata;
    end
    assign resTable[8*i +: 8] = resTbl[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrRes)
      resCnt <= '0;
    else if (stb.storeRes && resCnt < RES_W'(NRES))
      resCnt <= resCnt + 1'b1;
  end

  assign idxM1 = idx - 4'd1;

  always_comb begin
    if (idx == 4'd0)        busWdata = curOp;
    else if (isSpec)        busWdata = (idx == 4'd1) ? SPEC_A : SPEC_B;
    else                    busWdata = parTbl[idxM1];
  end

  assign lastByte = (idx == curLen);
  assign res0     = resTbl[0];
  assign resCount = resCnt;

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.incIdx |-> idx <= curLen);
  // R6
  res_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.storeRes && resCnt == RES_W'(NRES)) |=> resCnt == RES_W'(NRES));
endmodule

// File: rtl/fdc_hs_ctrl.sv
module fdc_hs_ctrl
  import fdc_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       intLine,
  input  logic [7:0] busRdata,
  input  logic [7:0] res0,
  input  logic       lastByte,
  output logic       busRd,
  output logic       busWr,
  output logic       busAddr,
  output logic       done,
  output logic       badInt,
  output logic       earlyEnd,
  output hsStrobe_t  stb
);
  typedef enum logic [3:0] {
    S_IDLE, S_BUSYCHK, S_TXPOLL, S_TXWR, S_RXPOLL, S_RXRD,
    S_INTWAIT, S_INTCHK, S_SEEKCHK
  } state_t;

  state_t st, stNext;
  logic   inInt, inIntNext;
  logic   doneNext, badNext, earlyNext;
  logic   rqm, dio, fdcBusy;

  assign rqm     = busRdata[7];
  assign dio     = busRdata[6];
  assign fdcBusy = busRdata[4];

  always_comb begin
    stNext    = st;
    inIntNext = inInt;
    doneNext  = 1'b0;
    badNext   = 1'b0;
    earlyNext = 1'b0;
    stb       = '0;
    busRd     = 1'b0;
    busWr     = 1'b0;
    busAddr   = 1'b0;
    case (st)
      S_IDLE: if (reqValid) begin
        stb.clrRes = 1'b1;
        if (reqKind == K_INT) begin
          inIntNext = 1'b1;
          stNext    = S_INTWAIT;
        end else begin
          inIntNext   = 1'b0;
          stb.loadCmd = 1'b1;
          stNext      = S_BUSYCHK;
        end
      end
      S_BUSYCHK: begin
        busRd = 1'b1;
        if (!fdcBusy) stNext = S_TXPOLL;
      end
      S_TXPOLL: begin
        busRd = 1'b1;
        if (rqm) begin
          if (dio) begin
            doneNext  = 1'b1;
            earlyNext = 1'b1;
            stNext    = S_IDLE;
          end else begin
            stNext = S_TXWR;
          end
        end
      end
      S_TXWR: begin
        busWr      = 1'b1;
        busAddr    = 1'b1;
        stb.incIdx = 1'b1;
        stNext     = lastByte ? S_RXPOLL : S_TXPOLL;
      end
      S_RXPOLL: begin
        busRd = 1'b1;
        if (rqm) begin
          if (dio)                                         stNext = S_RXRD;
          else if (inInt && (res0 & 8'hC0) == 8'hC0)       stNext = S_SEEKCHK;
          else begin
            doneNext = 1'b1;
            stNext   = S_IDLE;
          end
        end
      end
      S_RXRD: begin
        busRd        = 1'b1;
        busAddr      = 1'b1;
        stb.storeRes = 1'b1;
        stNext       = S_RXPOLL;
      end
      S_INTWAIT: if (intLine) begin
        stb.clrRes = 1'b1;
        stNext     = S_INTCHK;
      end
      S_INTCHK: begin
        busRd = 1'b1;
        if (fdcBusy) begin
          stNext = S_RXPOLL;
        end else begin
          stb.loadSense = 1'b1;
          stNext        = S_BUSYCHK;
        end
      end
      S_SEEKCHK: begin
        busRd = 1'b1;
        if ((busRdata & 8'h0F) != 8'h00) begin
          badNext = 1'b1;
          stNext  = S_INTWAIT;
        end else begin
          doneNext = 1'b1;
          stNext   = S_IDLE;
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= S_IDLE;
      inInt    <= 1'b0;
      done     <= 1'b0;
      badInt   <= 1'b0;
      earlyEnd <= 1'b0;
    end else begin
      st       <= stNext;
      inInt    <= inIntNext;
      done     <= doneNext;
      badInt   <= badNext;
      earlyEnd <= earlyNext;
    end
  end

  // R3
  wr_after_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> $past(busRd && !busAddr && busRdata[7] && !busRdata[6]));
  // R3
  rd_after_dio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr) |-> $past(busRd && !busAddr && busRdata[7] && busRdata[6]));
  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10
  bad_int_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    badInt |-> (!done && !earlyEnd));
  // R5
  early_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    earlyEnd |-> done);
endmodule

// File: rtl/fdc_handshake.sv
module fdc_handshake
  import fdc_hs_pkg::*;
#(
  parameter int STEP_MS   = 6,
  parameter int UNLOAD_MS = 240,
  parameter int LOAD_MS   = 50,
  parameter int NON_DMA   = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic [7:0]          reqOp,
  input  logic [3:0]          reqLen,
  input  logic [8*NPARAM-1:0] reqParams,
  input  logic                intLine,
  output logic                busAddr,
  output logic                busRd,
  output logic                busWr,
  output logic [7:0]          busWdata,
  input  logic [7:0]          busRdata,
  output logic                done,
  output logic                earlyEnd,
  output logic                badInt,
  output logic [RES_W-1:0]    resCount,
  output logic [8*NRES-1:0]   resTable
);
  hsStrobe_t  stb;
  logic       lastByte;
  logic [7:0] res0;

  fdc_hs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .intLine(intLine), .busRdata(busRdata), .res0(res0), .lastByte(lastByte),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr), .done(done),
    .badInt(badInt), .earlyEnd(earlyEnd), .stb(stb)
  );

  fdc_hs_dp #(
    .STEP_MS(STEP_MS), .UNLOAD_MS(UNLOAD_MS), .LOAD_MS(LOAD_MS), .NON_DMA(NON_DMA)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqKind(reqKind), .reqOp(reqOp),
    .reqLen(reqLen), .reqParams(reqParams), .busRdata(busRdata),
    .busWdata(busWdata), .lastByte(lastByte), .res0(res0),
    .resCount(resCount), .resTable(resTable)
  );
endmodule

// File: tb/tb_fdc_handshake.sv
module tb_fdc_handshake;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [7:0]  reqOp = 8'h00;
  logic [3:0]  reqLen = 4'd0;
  logic [71:0] reqParams = '0;
  logic        busAddr, busRd, busWr, done, earlyEnd, badInt;
  logic [7:0]  busWdata, busRdata;
  logic [2:0]  resCount;
  logic [55:0] resTable;

  int checks = 0, fails = 0;
  bit finished = 0;

  // controller model
  int wrCount, acceptN, resN, resPtr, holdCnt, busyHold;
  logic busyF, intL, badWr, badRd, badBusy;
  logic [3:0] seekB;
  logic [7:0] wrLog [0:15];
  logic [7:0] resQ  [0:7];
  logic rqmW, dioW, busyW;
  logic [7:0] statusW;

  always #10 clk = ~clk;

  fdc_handshake dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqOp(reqOp), .reqLen(reqLen), .reqParams(reqParams), .intLine(intL),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .done(done), .earlyEnd(earlyEnd), .badInt(badInt),
    .resCount(resCount), .resTable(resTable)
  );

  assign rqmW    = (holdCnt == 0);
  assign dioW    = (wrCount >= acceptN) && (resPtr < resN);
  assign busyW   = busyF || (busyHold > 0);
  assign statusW = {rqmW, dioW, 1'b0, busyW, seekB};
  assign busRdata = busAddr ? ((resPtr < 8) ? resQ[resPtr] : 8'hFF) : statusW;

  always @(posedge clk) begin
    if (holdCnt > 0)  holdCnt  <= holdCnt - 1;
    if (busyHold > 0) busyHold <= busyHold - 1;
    if (busWr && busAddr) begin
      if (!rqmW || dioW) badWr <= 1'b1;
      if (busyW) badBusy <= 1'b1;
      if (wrCount < 16) wrLog[wrCount] <= busWdata;
      wrCount <= wrCount + 1;
      holdCnt <= 2;
    end
    if (busRd && busAddr) begin
      if (!rqmW || !dioW) badRd <= 1'b1;
      resPtr  <= resPtr + 1;
      holdCnt <= 2;
      intL    <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic resetModel();
    wrCount = 0; acceptN = 0; resN = 0; resPtr = 0; holdCnt = 0; busyHold = 0;
    busyF = 0; intL = 0; badWr = 0; badRd = 0; badBusy = 0; seekB = 4'h0;
    for (int i = 0; i < 8; i++) resQ[i] = 8'h00;
    for (int i = 0; i < 16; i++) wrLog[i] = 8'h00;
  endtask

  task automatic issue(input logic [1:0] kind, input logic [7:0] op, input logic [3:0] len);
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqOp = op; reqLen = len;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // waits for done or badInt; checks the pulse lasts one cycle (R12)
  task automatic waitEvt(output bit gDone, output bit gBad, output bit gEarly);
    bit seen = 0;
    gDone = 0; gBad = 0; gEarly = 0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      if (done || badInt) begin
        seen = 1; gDone = done; gBad = badInt; gEarly = earlyEnd;
      end else @(negedge clk);
    end
    chk(seen, "R12 event seen", seen, 1);
    @(negedge clk);
    chk(!done && !badInt, "R12 single-cycle pulse", {done, badInt}, 0);
  endtask

  task automatic checkBus(input string req);
    chk(!badWr && !badRd, req, {badWr, badRd}, 0);
  endtask

  task automatic tReset();
    chk(!done && !badInt && !earlyEnd && !busRd && !busWr && resCount == 0,
        "R1 reset state", {done, badInt, earlyEnd, busRd, busWr, resCount}, 0);
  endtask

  task automatic tReadCmd();
    bit d, b, e;
    logic [7:0] p [0:8];
    p = '{8'h00, 8'h05, 8'h00, 8'h0C, 8'h00, 8'h0C, 8'h07, 8'h80, 8'hEE};
    resetModel();
    for (int k = 0; k < 9; k++) reqParams[8*k +: 8] = p[k];
    busyHold = 8; acceptN = 9; resN = 7;
    for (int i = 0; i < 7; i++) resQ[i] = 8'h40 + 8'(i);
    issue(2'd0, 8'h06, 4'd8);
    waitEvt(d, b, e);
    chk(d && !e && !b, "R7 normal completion", {d, e, b}, 3'b100);
    chk(!badBusy, "R2 no write while busy", badBusy, 0);
    checkBus("R3 status pacing");
    chk(wrCount == 9, "R4 byte count", wrCount, 9);
    chk(wrLog[0] == 8'h06, "R4 opcode first", wrLog[0], 8'h06);
    for (int k = 0; k < 8; k++)
      chk(wrLog[k+1] == p[k], "R4 parameter order", wrLog[k+1], p[k]);
    chk(resCount == 7, "R6 result count", resCount, 7);
    for (int i = 0; i < 7; i++)
      chk(resTable[8*i +: 8] == 8'h40 + 8'(i), "R6 result slot", resTable[8*i +: 8], 8'h40 + i);
  endtask

  task automatic tSeekCmd();
    bit d, b, e;
    resetModel();
    reqParams[7:0] = 8'h01; reqParams[15:8] = 8'h22;
    acceptN = 3; resN = 0;
    issue(2'd0, 8'h0F, 4'd2);
    waitEvt(d, b, e);
    chk(d && !e, "R7 empty result phase", {d, e}, 2'b10);
    chk(wrCount == 3 && wrLog[1] == 8'h01 && wrLog[2] == 8'h22, "R4 short command",
        wrCount, 3);
    chk(resCount == 0, "R7 no results", resCount, 0);
  endtask

  task automatic tEarly();
    bit d, b, e;
    resetModel();
    acceptN = 3; resN = 2; resQ[0] = 8'h48; resQ[1] = 8'h01;
    issue(2'd0, 8'h06, 4'd8);
    waitEvt(d, b, e);
    chk(d && e, "R5 early end flagged", {d, e}, 2'b11);
    chk(wrCount == 3, "R5 remaining bytes not sent", wrCount, 3);
    checkBus("R3 pacing early");
  endtask

  task automatic tSpecify();
    bit d, b, e;
    resetModel();
    acceptN = 3; resN = 0;
    issue(2'd1, 8'h00, 4'd0);
    waitEvt(d, b, e);
    chk(d && wrCount == 3, "R11 specify length", wrCount, 3);
    chk(wrLog[0] == 8'h03, "R11 specify opcode", wrLog[0], 8'h03);
    chk(wrLog[1] == 8'hAF, "R11 specify timing A", wrLog[1], 8'hAF);
    chk(wrLog[2] == 8'h33, "R11 specify timing B", wrLog[2], 8'h33);
  endtask

  task automatic tIntDirect();
    bit d, b, e;
    resetModel();
    busyF = 1; acceptN = 0; resN = 3;
    resQ[0] = 8'h01; resQ[1] = 8'h00; resQ[2] = 8'h00;
    issue(2'd2, 8'h00, 4'd0);
    repeat (20) @(negedge clk);
    chk(!done && resPtr == 0, "R8 waits for interrupt line", resPtr, 0);
    intL = 1;
    waitEvt(d, b, e);
    chk(d && !b, "R8 direct service done", {d, b}, 2'b10);
    chk(wrCount == 0, "R8 no write when busy", wrCount, 0);
    chk(resCount == 3 && resTable[7:0] == 8'h01, "R8 direct results", resCount, 3);
  endtask

  task automatic tIntSense();
    bit d, b, e;
    resetModel();
    acceptN = 1; resN = 2; resQ[0] = 8'h20; resQ[1] = 8'h05; intL = 1;
    issue(2'd2, 8'h00, 4'd0);
    waitEvt(d, b, e);
    chk(d && wrCount == 1, "R9 single sense byte", wrCount, 1);
    chk(wrLog[0] == 8'h08, "R9 sense opcode", wrLog[0], 8'h08);
    chk(resTable[15:0] == 16'h0520 && resCount == 2, "R9 sense results", resTable[15:0], 16'h0520);
  endtask

  task automatic tReadyChange();
    bit d, b, e;
    resetModel();
    seekB = 4'b0100; acceptN = 1; resN = 2; resQ[0] = 8'hC0; resQ[1] = 8'h00; intL = 1;
    issue(2'd2, 8'h00, 4'd0);
    waitEvt(d, b, e);
    chk(b && !d, "R10 ready change while seeking invalid", {b, d}, 2'b10);
    resetModel();
    acceptN = 1; resN = 2; resQ[0] = 8'h20; resQ[1] = 8'h07; intL = 1;
    waitEvt(d, b, e);
    chk(d && !b && resTable[7:0] == 8'h20, "R10 keeps waiting then completes",
        resTable[7:0], 8'h20);
    resetModel();
    acceptN = 1; resN = 2; resQ[0] = 8'hC0; resQ[1] = 8'h00; intL = 1;
    issue(2'd2, 8'h00, 4'd0);
    waitEvt(d, b, e);
    chk(d && !b, "R10 ready change without seeking valid", {d, b}, 2'b10);
  endtask

  task automatic tOverflow();
    bit d, b, e;
    resetModel();
    acceptN = 1; resN = 8;
    for (int i = 0; i < 8; i++) resQ[i] = 8'hA0 + 8'(i);
    issue(2'd0, 8'h0A, 4'd0);
    waitEvt(d, b, e);
    chk(resPtr == 8, "R6 all bytes drained", resPtr, 8);
    chk(resCount == 7, "R6 count saturates", resCount, 7);
    chk(resTable[55:48] == 8'hA6, "R6 last slot keeps seventh", resTable[55:48], 8'hA6);
  endtask

  initial begin
    resetModel();
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReadCmd();
    tSeekCmd();
    tEarly();
    tSpecify();
    tIntDirect();
    tIntSense();
    tReadyChange();
    tOverflow();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule